// File: doc/BRIEF.md
# Three-Address Memory-to-Memory Virtual Machine Core

This core runs a tiny virtual instruction set whose only architectural register is the program counter. Every instruction is four consecutive words in a single unified memory: an opcode word followed by three address words, called A, B and C. Operands are fetched from the memory words that B and C point at, and the result lands in the word that A points at. There is no immediate form. Constants, pointers and jump targets are simply words placed in memory before the program starts.

The core drives one synchronous, word-wide memory port. It carries both reads and writes, one access per cycle, and read data returns one cycle after the address. A multi-state sequencer first fetches the four instruction words. It then issues the operand reads, any pointer-chasing reads for the indirect forms, and finally a single writeback. Opcode 0, any unassigned opcode and any opcode word with bits set above bit 3 stop the machine in a sticky halted state. Only reset leaves that state. Data and address words are 32 bits wide, and only the low 21 bits of an address reach the port.

Opcode encoding (opcode word value): 0 halt, 1 jump, 2 jump-if-zero, 3 add, 4 subtract, 5 indirect load, 6 indirect store, 7 multiply, 8 divide, 9 modulo, 10 AND, 12 less-than. The values 11 and 13 to 15 are unassigned.

Top module: `mm3_core`

## Requirements
- R1: While rst_n is low, halted is 0, mem_we is 0 and mem_addr is 0, so the first fetch after reset reads address 0.
- R2: Opcodes 3, 4 and 7 write M[B]+M[C], M[B]-M[C] and the low 32 bits of M[B]*M[C] to M[A], each modulo 2^32.
- R3: Opcodes 8 and 9 write the unsigned quotient and the unsigned remainder of M[B] by M[C] to M[A]. Both write 0 when M[C] is 0.
- R4: Opcode 10 writes the bitwise AND of M[B] and M[C] to M[A]. It is the only logical operation.
- R5: Opcode 12 writes 1 to M[A] when M[B] < M[C] as unsigned numbers, and 0 otherwise.
- R6: Opcode 1 loads the PC with the low 21 bits of M[A] and writes no memory.
- R7: Opcode 2 loads the PC with the low 21 bits of M[A] when M[B] is 0. Otherwise execution falls through to the next instruction.
- R8: Opcode 5 performs M[A] <- M[M[B]].
- R9: Opcode 6 performs M[M[B]] <- M[M[A]] and leaves M[A] and M[B] unchanged.
- R10: Opcode word 0, 11, 13, 14, 15, or any word with a bit set above bit 3, raises halted. The core then writes nothing and stays halted until reset.
- R11: After a non-branch instruction the PC advances by 4, so the instruction in the next four words runs next.
- R12: Each instruction that stores a result performs exactly one memory write, and two writes never occur in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | 21 | Word address for the current read or write |
| mem_we | output | 1 | Write strobe; mem_wdata is stored at mem_addr at the clock edge |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Word read from the address presented one cycle earlier |
| halted | output | 1 | Sticky halt indication |

## Verification
The assertions assume that the memory returns, one cycle after each address, the word held at that address. They also assume that nothing outside the core writes memory while it runs, since the divide-by-zero and compare checks relate the write data to the operands latched from the port. The bench meets these assumptions with a behavioural memory that reads first and is written only through mem_we. It preloads all program and data words while reset is held, and every pointer it plants stays inside the modelled 256 words. Each run is restarted through reset, so a halt left over from one program never leaks into the next.

// File: rtl/mm3_pkg.sv
package mm3_pkg;

  localparam logic [3:0] OP_HALT = 4'd0;
  localparam logic [3:0] OP_JMP  = 4'd1;
  localparam logic [3:0] OP_JZ   = 4'd2;
  localparam logic [3:0] OP_ADD  = 4'd3;
  localparam logic [3:0] OP_SUB  = 4'd4;
  localparam logic [3:0] OP_LDI  = 4'd5;
  localparam logic [3:0] OP_STI  = 4'd6;
  localparam logic [3:0] OP_MUL  = 4'd7;
  localparam logic [3:0] OP_DIV  = 4'd8;
  localparam logic [3:0] OP_MOD  = 4'd9;
  localparam logic [3:0] OP_AND  = 4'd10;
  localparam logic [3:0] OP_LT   = 4'd12;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3, S_F4, S_R1, S_R2, S_R3, S_WB, S_HALT
  } state_e;

  typedef struct packed {
    logic jmp;
    logic jz;
    logic ldi;
    logic sti;
    logic alu;
    logic illegal;
  } opclass_t;

endpackage

// File: rtl/mm3_decode.sv
module mm3_decode
  import mm3_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word_i,
  output logic [3:0]    code_o,
  output opclass_t      cls_o
);

  logic upper_clear;

  assign upper_clear = (word_i[DW-1:4] == '0);
  assign code_o      = word_i[3:0];

  always_comb begin
    cls_o = '0;
    unique case (code_o)
      OP_JMP:  cls_o.jmp = 1'b1;
      OP_JZ:   cls_o.jz  = 1'b1;
      OP_LDI:  cls_o.ldi = 1'b1;
      OP_STI:  cls_o.sti = 1'b1;
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD, OP_AND, OP_LT:
               cls_o.alu = 1'b1;
      default: cls_o.illegal = 1'b1;
    endcase
    if (!upper_clear) cls_o = '{illegal: 1'b1, default: 1'b0};
  end

endmodule

// File: rtl/mm3_alu.sv
module mm3_alu
  import mm3_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    code_i,
  input  logic [DW-1:0] lhs_i,
  input  logic [DW-1:0] rhs_i,
  output logic [DW-1:0] res_o
);

  logic          rhs_zero;
  logic [2*DW-1:0] prod;

  assign rhs_zero = (rhs_i == '0);
  assign prod     = lhs_i * rhs_i;

  always_comb begin
    unique case (code_i)
      OP_ADD:  res_o = lhs_i + rhs_i;
      OP_SUB:  res_o = lhs_i - rhs_i;
      OP_MUL:  res_o = prod[DW-1:0];
      OP_DIV:  res_o = rhs_zero ? '0 : lhs_i / rhs_i;
      OP_MOD:  res_o = rhs_zero ? '0 : lhs_i % rhs_i;
      OP_AND:  res_o = lhs_i & rhs_i;
      OP_LT:   res_o = {{(DW-1){1'b0}}, (lhs_i < rhs_i)};
      default: res_o = rhs_i;  // indirect moves carry the fetched word
    endcase
  end

endmodule

// File: rtl/mm3_core.sv
module mm3_core
  import mm3_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 21,
  parameter int unsigned RESET_PC = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);

  localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);
  localparam logic [AW-1:0] STEP    = AW'(4);

  state_e          state_q, state_d;
  logic [AW-1:0]   pc_q, pc_d;
  logic [3:0]      code_q, dec_code;
  opclass_t        cls_q, dec_cls;
  logic [AW-1:0]   fa_q, fb_q, fc_q;
  logic [DW-1:0]   x_q, y_q;
  logic [DW-1:0]   alu_res;
  logic            pc_en, op_en, fa_en, fb_en, fc_en, x_en, y_en;

  mm3_decode #(.DW(DW)) i_decode (
    .word_i (mem_rdata),
    .code_o (dec_code),
    .cls_o  (dec_cls)
  );

  mm3_alu #(.DW(DW)) i_alu (
    .code_i (code_q),
    .lhs_i  (x_q),
    .rhs_i  (y_q),
    .res_o  (alu_res)
  );

  // next-state and port drive
  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q + STEP;
    pc_en    = 1'b0;
    op_en    = 1'b0;
    fa_en    = 1'b0;
    fb_en    = 1'b0;
    fc_en    = 1'b0;
    x_en     = 1'b0;
    y_en     = 1'b0;
    mem_addr = pc_q;
    mem_we   = 1'b0;
    unique case (state_q)
      S_F0: state_d = S_F1;
      S_F1: begin
        mem_addr = pc_q + AW'(1);
        op_en    = 1'b1;
        state_d  = dec_cls.illegal ? S_HALT : S_F2;
      end
      S_F2: begin
        mem_addr = pc_q + AW'(2);
        fa_en    = 1'b1;
        state_d  = S_F3;
      end
      S_F3: begin
        mem_addr = pc_q + AW'(3);
        fb_en    = 1'b1;
        state_d  = S_F4;
      end
      S_F4: begin
        fc_en    = 1'b1;
        mem_addr = cls_q.jmp ? fa_q : fb_q;
        state_d  = S_R1;
      end
      S_R1: begin
        x_en = 1'b1;
        if (cls_q.jmp) begin
          pc_en   = 1'b1;
          pc_d    = mem_rdata[AW-1:0];
          state_d = S_F0;
        end else begin
          if (cls_q.ldi)      mem_addr = mem_rdata[AW-1:0];
          else if (cls_q.alu) mem_addr = fc_q;
          else                mem_addr = fa_q;
          state_d = S_R2;
        end
      end
      S_R2: begin
        y_en = 1'b1;
        if (cls_q.sti) begin
          mem_addr = mem_rdata[AW-1:0];
          state_d  = S_R3;
        end else if (cls_q.jz) begin
          pc_en = 1'b1;
          if (x_q == '0) pc_d = mem_rdata[AW-1:0];
          state_d = S_F0;
        end else begin
          state_d = S_WB;
        end
      end
      S_R3: begin
        y_en    = 1'b1;
        state_d = S_WB;
      end
      S_WB: begin
        mem_we   = 1'b1;
        mem_addr = cls_q.sti ? x_q[AW-1:0] : fa_q;
        pc_en    = 1'b1;
        state_d  = S_F0;
      end
      S_HALT: state_d = S_HALT;
      default: state_d = S_HALT;
    endcase
  end

  assign mem_wdata = alu_res;
  assign halted    = (state_q == S_HALT);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_F0;
      pc_q    <= PC_INIT;
      code_q  <= '0;
      cls_q   <= '0;
      fa_q    <= '0;
      fb_q    <= '0;
      fc_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_d;
      if (op_en) begin
        code_q <= dec_code;
        cls_q  <= dec_cls;
      end
      if (fa_en) fa_q <= mem_rdata[AW-1:0];
      if (fb_en) fb_q <= mem_rdata[AW-1:0];
      if (fc_en) fc_q <= mem_rdata[AW-1:0];
      if (x_en)  x_q  <= mem_rdata;
      if (y_en)  y_q  <= mem_rdata;
    end
  end

endmodule

// File: rtl/mm3_core_chk.sv
module mm3_core_chk
  import mm3_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halted,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input state_e        state_q,
  input logic [AW-1:0] pc_q,
  input logic [3:0]    code_q,
  input logic [DW-1:0] y_q
);

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  p_single_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_pc_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WB) |=> (pc_q == $past(pc_q) + AW'(4)));

  p_div_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (code_q == OP_DIV || code_q == OP_MOD) && y_q == '0)
      |-> (mem_wdata == '0));

  p_lt_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && code_q == OP_LT) |-> (mem_wdata[DW-1:1] == '0));

endmodule

bind mm3_core mm3_core_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .halted    (halted),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .state_q   (state_q),
  .pc_q      (pc_q),
  .code_q    (code_q),
  .y_q       (y_q)
);

// File: tb/test_mm3_core.sv
module test_mm3_core;

  localparam int DW = 32;
  localparam int AW = 21;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          halted;

  logic [DW-1:0] mem [256];
  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  mm3_core #(.DW(DW), .AW(AW)) i_mm3_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic put_ins(input int at, input logic [DW-1:0] op, input int a, input int b, input int c);
    mem[at]   = op;
    mem[at+1] = DW'(a);
    mem[at+2] = DW'(b);
    mem[at+3] = DW'(c);
  endtask

  // reset, run until halt, count writes
  task automatic run(output int writes);
    int n;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    writes = 0;
    n = 0;
    while (!halted && n < 400) begin
      if (mem_we) writes++;
      n++;
      @(negedge clk);
    end
    if (!halted) chk("run-timeout", 32'(n), 32'd0);
  endtask

  function automatic logic [DW-1:0] model(input logic [3:0] op, input logic [DW-1:0] b, input logic [DW-1:0] c);
    case (op)
      4'd3:  return b + c;
      4'd4:  return b - c;
      4'd7:  return b * c;
      4'd8:  return (c == 0) ? 0 : b / c;
      4'd9:  return (c == 0) ? 0 : b % c;
      4'd10: return b & c;
      default: return (b < c) ? 1 : 0;
    endcase
  endfunction

  logic [DW-1:0] vals [8];
  logic [3:0]    ops  [7];

  initial begin
    int w;
    vals = '{32'h0, 32'h1, 32'h2, 32'h7, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'h0000_FFFF};
    ops  = '{4'd3, 4'd4, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12};
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 halted", 32'(halted), 0);
    chk("R1 mem_we", 32'(mem_we), 0);
    chk("R1 mem_addr", 32'(mem_addr), 0);

    // R2 R3 R4 R5 sweep, R12 write count
    foreach (ops[k]) begin
      foreach (vals[i]) begin
        foreach (vals[j]) begin
          clear_mem();
          put_ins(0, 32'(ops[k]), 100, 101, 102);
          mem[100] = 32'hDEAD_0000;
          mem[101] = vals[i];
          mem[102] = vals[j];
          run(w);
          case (ops[k])
            4'd3, 4'd4, 4'd7: chk("R2 arith", mem[100], model(ops[k], vals[i], vals[j]));
            4'd8, 4'd9:       chk("R3 div/mod", mem[100], model(ops[k], vals[i], vals[j]));
            4'd10:            chk("R4 and", mem[100], model(ops[k], vals[i], vals[j]));
            default:          chk("R5 lt", mem[100], model(ops[k], vals[i], vals[j]));
          endcase
          if (j == 0) chk("R12 one write", 32'(w), 1);
        end
      end
    end

    // R11 sequential execution
    clear_mem();
    put_ins(0, 3, 100, 101, 102);
    put_ins(4, 4, 103, 100, 102);
    mem[101] = 32'd1000; mem[102] = 32'd37;
    run(w);
    chk("R11 second ins", mem[103], 32'd1000);
    chk("R12 two writes", 32'(w), 2);

    // R6 jump, target uses low 21 bits only
    clear_mem();
    put_ins(0, 1, 50, 0, 0);
    put_ins(4, 3, 104, 110, 111);
    put_ins(12, 3, 105, 110, 111);
    mem[50] = 32'hFFE0_000C; mem[110] = 5; mem[111] = 6;
    run(w);
    chk("R6 skipped", mem[104], 0);
    chk("R6 target ran", mem[105], 11);
    chk("R6 writes", 32'(w), 1);

    // R7 jump-if-zero taken / not taken
    for (int t = 0; t < 2; t++) begin
      clear_mem();
      put_ins(0, 2, 50, 51, 0);
      put_ins(4, 3, 104, 110, 111);
      put_ins(12, 3, 105, 110, 111);
      mem[50] = 12; mem[51] = (t == 0) ? 0 : 3; mem[110] = 5; mem[111] = 6;
      run(w);
      chk("R7 fallthrough slot", mem[104], (t == 0) ? 0 : 11);
      chk("R7 target slot", mem[105], (t == 0) ? 11 : 0);
    end

    // R8 indirect load
    clear_mem();
    put_ins(0, 5, 100, 60, 0);
    mem[60] = 70; mem[70] = 32'hCAFE_F00D;
    run(w);
    chk("R8 ldi", mem[100], 32'hCAFE_F00D);

    // R9 indirect store
    clear_mem();
    put_ins(0, 6, 61, 60, 0);
    mem[60] = 80; mem[61] = 71; mem[71] = 32'hBEEF_0123;
    run(w);
    chk("R9 sti dest", mem[80], 32'hBEEF_0123);
    chk("R9 A kept", mem[61], 71);
    chk("R9 B kept", mem[60], 80);
    chk("R12 sti one write", 32'(w), 1);

    // R10 halting opcodes
    begin
      logic [DW-1:0] hops [6];
      hops = '{32'd0, 32'd11, 32'd13, 32'd14, 32'd15, 32'h13};
      foreach (hops[h]) begin
        clear_mem();
        put_ins(0, hops[h], 100, 101, 102);
        put_ins(4, 3, 103, 101, 102);
        mem[100] = 32'h5A5A_5A5A; mem[101] = 3; mem[102] = 4;
        run(w);
        chk("R10 halted", 32'(halted), 1);
        chk("R10 no write", 32'(w), 0);
        chk("R10 A kept", mem[100], 32'h5A5A_5A5A);
        repeat (20) @(negedge clk);
        chk("R10 sticky", 32'(halted), 1);
        chk("R10 next ins idle", mem[103], 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule